// File: doc/BRIEF.md
# E1 Transmit Clock-Slave Serial Capture

This block takes in the serial transmit stream of up to two E1 links when the system side owns the timing. It receives each link's bit clock, frame pulse, data and signaling lines, and turns them into one byte per timeslot. It also reports the timeslot and frame position of each byte. Everything runs on a fast internal clock that oversamples the external lines. The external clock and frame pulse pass through a two-flop synchronizer. Edges are then found by comparing the synchronized level with its value one cycle earlier. The data and signaling lines go through the same number of stages, so they stay aligned with the clock.

Each link has its own settings:
- The external clock runs at the data rate (2.048 MHz) or at twice that rate (4.096 MHz).
- Configurable clock edges capture the frame pulse and the data.
- At double rate, a half-select chooses which of the two active edges inside a bit takes the data.
- The frame pulse has a polarity setting.
- A type field tells whether the pulse marks every frame or the start of a 16-frame multiframe.

A share setting lets link 2 follow link 1's clock and frame pulse. Link 2 still uses its own data and signaling lines. Slip buffering and line-side work belong elsewhere.

Top module: `e1_tx_slave_capture`

## Requirements
- R1: After reset, and on any link whose `link_slave` bit is 0, `byte_valid` and `resync` stay 0, and the link's `ts_num` and `frm_num` fields read 0. A disabled link ignores its line inputs.
- R2: At single rate, the data line is captured on each active data edge: rising when `dat_edge`=0, falling when `dat_edge`=1. Bits are sent most significant first. After bit 7 of each timeslot, a one-cycle `byte_valid` pulse presents the byte and its timeslot number, 0 to 31.
- R3: The frame pulse is captured on the edge set by `fp_edge` (0 rising, 1 falling). When `fp_edge` equals `dat_edge`, the bit captured at that same edge is bit 0 of timeslot 0. When they differ, the pulse is taken half a clock earlier, and the next data edge carries bit 0.
- R4: With `rate2x`=1, each bit spans two external clock periods and so has two active data edges. `half_sel`=0 takes the data on the first of them and `half_sel`=1 on the second. The value on the other edge has no effect.
- R5: With `rate2x`=1, only the first active sample of a frame pulse counts. A pulse held for a whole bit (two clock periods) aligns the link once.
- R6: `fp_inv`=0 treats a high frame pulse as active. `fp_inv`=1 treats a low one as active.
- R7: `fp_type` encoding: 0 marks each frame, 1 the CRC multiframe, 2 the signaling multiframe, and 3 behaves as 0. The frame number counts 0 to 15 and wraps. It advances at each frame end and at each per-frame pulse after the link is locked. A multiframe pulse sets it to 0. The first pulse after reset starts at frame 0.
- R8: The signaling line is captured on the same edges and bit order as the data. It is presented as a byte in `byte_sig` together with the data byte.
- R9: While a link is locked, a pulse that does not fall on the expected frame boundary raises `resync` for one cycle and realigns the counters. For multiframe types, the expected boundary is the end of frame 15. The first alignment after reset never raises `resync`.
- R10: With `share_clk`=1 and both `link_slave` bits set, link 2 takes its clock and frame pulse from link 1 and its data and signaling from its own lines. In every other case each link uses its own clock and pulse. While sharing, both links must have the same `rate2x` setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| share_clk | input | 1 | Link 2 follows link 1 timing when both links are enabled |
| link_slave | input | 2 | Per-link enable of slave capture |
| rate2x | input | 2 | Per link: 1 = external clock at twice the data rate |
| fp_edge | input | 2 | Per link: frame pulse sampling edge, 0 rising / 1 falling |
| dat_edge | input | 2 | Per link: data sampling edge, 0 rising / 1 falling |
| half_sel | input | 2 | Per link: double-rate edge choice, 0 first / 1 second |
| fp_type | input | 4 | Per link, 2 bits each: pulse meaning |
| fp_inv | input | 2 | Per link: 1 = frame pulse active low |
| ext_clk | input | 2 | External bit clocks |
| ext_fp | input | 2 | External frame pulses |
| ext_dat | input | 2 | Serial transmit data |
| ext_sig | input | 2 | Serial signaling bits |
| byte_valid | output | 2 | One-cycle strobe per captured timeslot |
| byte_dat | output | 16 | Captured data bytes, 8 bits per link |
| byte_sig | output | 16 | Captured signaling bytes, 8 bits per link |
| ts_num | output | 10 | Timeslot number of the byte, 5 bits per link |
| frm_num | output | 8 | Frame number of the byte, 4 bits per link |
| resync | output | 2 | One-cycle flag on an off-position frame pulse |

## Verification
The assertions assume that the external clock period is at least four fast cycles. They also assume that data, signaling and frame pulse change only on the clock edge opposite to the one that samples them, and that both links carry equal rate settings whenever sharing is active. The bench produces every external line from a half-period stepper of four fast cycles each, which gives eight times oversampling. It changes data only on the non-sampling transition and the frame pulse only on the transition away from the pulse-sampling edge. It pairs the share setting with equal rates. Under those conditions the timeslot numbers on successive bytes step by one within a frame, and the frame number holds steady across the bytes of a frame. A captured byte can never be followed by another in the next fast cycle.

// File: rtl/e1cap_pkg.sv
package e1cap_pkg;
    localparam int TS_BITS     = 8;
    localparam int TS_PER_FRM  = 32;
    localparam int FRM_PER_MF  = 16;
    localparam int BITS_PER_FRM = TS_BITS * TS_PER_FRM;
    localparam int POS_W       = $clog2(2 * BITS_PER_FRM);
    localparam int BIT_W       = $clog2(TS_BITS);
    localparam int TS_W        = $clog2(TS_PER_FRM);
    localparam int FRM_W       = $clog2(FRM_PER_MF);

    typedef enum logic [1:0] {
        FPT_BASIC  = 2'd0,
        FPT_CRC_MF = 2'd1,
        FPT_SIG_MF = 2'd2,
        FPT_SPARE  = 2'd3
    } fp_kind_e;

    typedef struct packed {
        logic               clk_prev;
        logic               fp_prev;
        logic               align_pend;
        logic               locked;
        logic [POS_W-1:0]   pos;
        logic [FRM_W-1:0]   frm;
        logic [TS_BITS-1:0] shd;
        logic [TS_BITS-1:0] shs;
        logic               out_valid;
        logic [TS_BITS-1:0] out_dat;
        logic [TS_BITS-1:0] out_sig;
        logic [TS_W-1:0]    out_ts;
        logic [FRM_W-1:0]   out_frm;
        logic               resync;
    } cap_state_t;
endpackage

// File: rtl/e1cap_sync.sv
module e1cap_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_async,
    output logic [W-1:0] out_sync
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = in_async;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign out_sync = stg_q[STAGES-1];
endmodule

// File: rtl/e1cap_link.sv
module e1cap_link
    import e1cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               rate2x,
    input  logic               fp_edge,
    input  logic               dat_edge,
    input  logic               half_sel,
    input  logic [1:0]         fp_type,
    input  logic               fp_inv,
    input  logic               sclk,
    input  logic               sfp,
    input  logic               sdat,
    input  logic               ssig,
    output logic               byte_valid,
    output logic [TS_BITS-1:0] byte_dat,
    output logic [TS_BITS-1:0] byte_sig,
    output logic [TS_W-1:0]    ts_num,
    output logic [FRM_W-1:0]   frm_num,
    output logic               resync
);
    localparam logic [POS_W-1:0] LAST_1X = POS_W'(BITS_PER_FRM - 1);
    localparam logic [POS_W-1:0] LAST_2X = POS_W'(2 * BITS_PER_FRM - 1);
    localparam logic [FRM_W-1:0] LAST_FRM = FRM_W'(FRM_PER_MF - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(TS_BITS - 1);

    cap_state_t st_d, st_q;

    logic             rise, fall, ev_d, ev_f, fp_act, fp_take, align;
    logic             at_end, multi, take;
    logic [POS_W-1:0] last, cur;
    logic [POS_W-2:0] bidx;

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = 1'b0;
        st_d.resync    = 1'b0;
        st_d.clk_prev  = sclk;

        rise    = sclk & ~st_q.clk_prev;
        fall    = ~sclk & st_q.clk_prev;
        ev_d    = dat_edge ? fall : rise;
        ev_f    = fp_edge ? fall : rise;
        fp_act  = sfp ^ fp_inv;
        fp_take = ev_f && fp_act && (!rate2x || !st_q.fp_prev);
        if (ev_f) st_d.fp_prev = fp_act;

        align           = st_q.align_pend | fp_take;
        st_d.align_pend = align & ~ev_d;

        last   = rate2x ? LAST_2X : LAST_1X;
        at_end = (st_q.pos == last);
        multi  = (fp_type == FPT_CRC_MF) || (fp_type == FPT_SIG_MF);
        cur    = st_q.pos;
        take   = 1'b0;

        if (ev_d) begin
            if (align) begin
                cur         = '0;
                take        = 1'b1;
                st_d.locked = 1'b1;
                st_d.resync = st_q.locked &&
                              !(at_end && (!multi || st_q.frm == LAST_FRM));
                st_d.frm    = (multi || !st_q.locked) ? '0 : st_q.frm + FRM_W'(1);
            end else if (st_q.locked) begin
                take = 1'b1;
                cur  = at_end ? '0 : st_q.pos + POS_W'(1);
                if (at_end) st_d.frm = st_q.frm + FRM_W'(1);
            end
            st_d.pos = cur;
        end

        bidx = rate2x ? cur[POS_W-1:1] : cur[POS_W-2:0];

        if (take && (!rate2x || cur[0] == half_sel)) begin
            st_d.shd = {st_q.shd[TS_BITS-2:0], sdat};
            st_d.shs = {st_q.shs[TS_BITS-2:0], ssig};
            if (bidx[BIT_W-1:0] == LAST_BIT) begin
                st_d.out_valid = 1'b1;
                st_d.out_dat   = st_d.shd;
                st_d.out_sig   = st_d.shs;
                st_d.out_ts    = bidx[BIT_W +: TS_W];
                st_d.out_frm   = st_d.frm;
            end
        end

        if (!en) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_valid = st_q.out_valid;
    assign byte_dat   = st_q.out_dat;
    assign byte_sig   = st_q.out_sig;
    assign ts_num     = st_q.out_ts;
    assign frm_num    = st_q.out_frm;
    assign resync     = st_q.resync;

    // Checker state: last emitted timeslot and frame
    logic             chk_have_q;
    logic [TS_W-1:0]  chk_ts_q;
    logic [FRM_W-1:0] chk_frm_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            chk_have_q <= 1'b0;
            chk_ts_q   <= '0;
            chk_frm_q  <= '0;
        end else if (byte_valid) begin
            chk_have_q <= 1'b1;
            chk_ts_q   <= ts_num;
            chk_frm_q  <= frm_num;
        end
    end

    // R2
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && chk_have_q && ts_num != '0) |-> (ts_num == chk_ts_q + TS_W'(1)));

    // R7
    frm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && chk_have_q && ts_num != '0) |-> (frm_num == chk_frm_q));

    // R2
    byte_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    // R1
    idle_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!byte_valid && !resync));

    // R9
    resync_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |-> $past(st_q.locked));
endmodule

// File: rtl/e1_tx_slave_capture.sv
module e1_tx_slave_capture
    import e1cap_pkg::*;
#(
    parameter int NUM_LINKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       share_clk,
    input  logic [NUM_LINKS-1:0]       link_slave,
    input  logic [NUM_LINKS-1:0]       rate2x,
    input  logic [NUM_LINKS-1:0]       fp_edge,
    input  logic [NUM_LINKS-1:0]       dat_edge,
    input  logic [NUM_LINKS-1:0]       half_sel,
    input  logic [2*NUM_LINKS-1:0]     fp_type,
    input  logic [NUM_LINKS-1:0]       fp_inv,
    input  logic [NUM_LINKS-1:0]       ext_clk,
    input  logic [NUM_LINKS-1:0]       ext_fp,
    input  logic [NUM_LINKS-1:0]       ext_dat,
    input  logic [NUM_LINKS-1:0]       ext_sig,
    output logic [NUM_LINKS-1:0]       byte_valid,
    output logic [TS_BITS*NUM_LINKS-1:0] byte_dat,
    output logic [TS_BITS*NUM_LINKS-1:0] byte_sig,
    output logic [TS_W*NUM_LINKS-1:0]  ts_num,
    output logic [FRM_W*NUM_LINKS-1:0] frm_num,
    output logic [NUM_LINKS-1:0]       resync
);
    localparam int LINE_W = 4;

    logic                              shared;
    logic [NUM_LINKS-1:0][LINE_W-1:0]  syn;
    logic [NUM_LINKS-1:0]              src_clk, src_fp;

    assign shared = share_clk & (&link_slave);

    for (genvar g = 0; g < NUM_LINKS; g++) begin : g_link
        e1cap_sync #(.W(LINE_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .in_async ({ext_sig[g], ext_dat[g], ext_fp[g], ext_clk[g]}),
            .out_sync (syn[g])
        );

        if (g == 0) begin : g_own
            assign src_clk[g] = syn[g][0];
            assign src_fp[g]  = syn[g][1];
        end else begin : g_mux
            assign src_clk[g] = shared ? syn[0][0] : syn[g][0];
            assign src_fp[g]  = shared ? syn[0][1] : syn[g][1];
        end

        e1cap_link u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (link_slave[g]),
            .rate2x     (rate2x[g]),
            .fp_edge    (fp_edge[g]),
            .dat_edge   (dat_edge[g]),
            .half_sel   (half_sel[g]),
            .fp_type    (fp_type[2*g +: 2]),
            .fp_inv     (fp_inv[g]),
            .sclk       (src_clk[g]),
            .sfp        (src_fp[g]),
            .sdat       (syn[g][2]),
            .ssig       (syn[g][3]),
            .byte_valid (byte_valid[g]),
            .byte_dat   (byte_dat[TS_BITS*g +: TS_BITS]),
            .byte_sig   (byte_sig[TS_BITS*g +: TS_BITS]),
            .ts_num     (ts_num[TS_W*g +: TS_W]),
            .frm_num    (frm_num[FRM_W*g +: FRM_W]),
            .resync     (resync[g])
        );
    end

    // R10
    shared_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shared |-> (rate2x == {NUM_LINKS{rate2x[0]}}));
endmodule

// File: tb/sim_e1_tx_slave_capture.sv
module sim_e1_tx_slave_capture;
    import e1cap_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n;
    logic        share_clk;
    logic [1:0]  link_slave, rate2x, fp_edge, dat_edge, half_sel, fp_inv;
    logic [3:0]  fp_type;
    logic [1:0]  ext_clk, ext_fp, ext_dat, ext_sig;
    logic [1:0]  byte_valid, resync;
    logic [15:0] byte_dat, byte_sig;
    logic [9:0]  ts_num;
    logic [7:0]  frm_num;

    e1_tx_slave_capture u0 (
        .clk(clk), .rst_n(rst_n), .share_clk(share_clk), .link_slave(link_slave),
        .rate2x(rate2x), .fp_edge(fp_edge), .dat_edge(dat_edge), .half_sel(half_sel),
        .fp_type(fp_type), .fp_inv(fp_inv), .ext_clk(ext_clk), .ext_fp(ext_fp),
        .ext_dat(ext_dat), .ext_sig(ext_sig), .byte_valid(byte_valid),
        .byte_dat(byte_dat), .byte_sig(byte_sig), .ts_num(ts_num),
        .frm_num(frm_num), .resync(resync)
    );

    typedef struct {
        logic [7:0] d;
        logic [7:0] s;
        int         ts;
        int         fr;
        string      tag;
    } exp_t;

    exp_t  expq [2][$];
    exp_t  mon_item;
    int    n_chk = 0, n_bad = 0;
    int    rx_cnt [2];
    int    rs_cnt [2];
    bit    done = 1'b0;

    function automatic logic [7:0] pat(int lk, int k, int ts, int sel);
        return 8'((lk * 71 + k * 29 + ts * 13 + sel * 101 + 5) ^ (ts * 8));
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // Monitor: pops expected bytes and compares
    always @(negedge clk) begin
        if (rst_n) begin
            for (int g = 0; g < 2; g++) begin
                if (resync[g]) rs_cnt[g]++;
                if (byte_valid[g]) begin
                    rx_cnt[g]++;
                    if (expq[g].size() == 0) begin
                        chk(1'b0, "R1", $sformatf("link %0d unexpected byte", g),
                            longint'(byte_dat[8*g +: 8]), 0);
                    end else begin
                        mon_item = expq[g].pop_front();
                        chk(byte_dat[8*g +: 8] == mon_item.d, mon_item.tag,
                            $sformatf("link %0d data ts %0d", g, mon_item.ts),
                            longint'(byte_dat[8*g +: 8]), longint'(mon_item.d));
                        chk(byte_sig[8*g +: 8] == mon_item.s, "R8",
                            $sformatf("link %0d signaling ts %0d", g, mon_item.ts),
                            longint'(byte_sig[8*g +: 8]), longint'(mon_item.s));
                        chk(int'(ts_num[5*g +: 5]) == mon_item.ts, mon_item.tag,
                            $sformatf("link %0d timeslot", g),
                            longint'(ts_num[5*g +: 5]), longint'(mon_item.ts));
                        chk(int'(frm_num[4*g +: 4]) == mon_item.fr, "R7",
                            $sformatf("link %0d frame (%s)", g, mon_item.tag),
                            longint'(frm_num[4*g +: 4]), longint'(mon_item.fr));
                    end
                end
            end
        end
    end

    // Driver: sets config, resets, pushes expected bytes, plays the lines
    task automatic run_case(input string tag, input bit r2, input bit fe, input bit de,
                            input bit hs, input logic [1:0] ft, input bit inv,
                            input bit shr, input logic [1:0] slv, input int nfr,
                            input int cut0, input bit pulse_all);
        int  st [4];
        int  bits [4];
        bit  pulse [4];
        int  fnum [4];
        int  ppb, total, h0, hend, exp_rs, fn;
        bit  multi, both;
        exp_t it;

        ppb   = r2 ? 2 : 1;
        multi = (ft == 2'd1) || (ft == 2'd2);
        both  = shr && (slv == 2'b11);
        h0    = 8;

        rst_n      = 1'b0;
        share_clk  = shr;
        link_slave = slv;
        rate2x     = {2{r2}};
        fp_edge    = {2{fe}};
        dat_edge   = {2{de}};
        half_sel   = {2{hs}};
        fp_type    = {2{ft}};
        fp_inv     = {2{inv}};
        ext_clk    = 2'b00;
        ext_fp     = {2{inv}};
        ext_dat    = 2'b00;
        ext_sig    = 2'b00;
        for (int g = 0; g < 2; g++) begin
            expq[g].delete();
            rx_cnt[g] = 0;
            rs_cnt[g] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        total  = 0;
        exp_rs = 0;
        fn     = 0;
        for (int k = 0; k < nfr; k++) begin
            bits[k]  = (k == 0 && cut0 > 0) ? cut0 : 256;
            st[k]    = total;
            total   += bits[k] * ppb;
            pulse[k] = (k == 0) || pulse_all;
            if (k > 0) begin
                if (pulse[k]) begin
                    // R9: off-boundary pulse while locked
                    if (bits[k-1] != 256 || (multi && fn != 15)) exp_rs++;
                    fn = multi ? 0 : (fn + 1) % 16;
                end else begin
                    fn = (fn + 1) % 16;
                end
            end
            fnum[k] = fn;
        end
        for (int g = 0; g < 2; g++) begin
            if (slv[g]) begin
                for (int k = 0; k < nfr; k++) begin
                    for (int ts = 0; ts < bits[k] / 8; ts++) begin
                        it.d   = pat(g, k, ts, 0);
                        it.s   = pat(g, k, ts, 1);
                        it.ts  = ts;
                        it.fr  = fnum[k];
                        it.tag = tag;
                        expq[g].push_back(it);
                    end
                end
            end
        end

        hend = h0 + 2 * total + 6;
        for (int h = 0; h < hend; h++) begin
            logic lvl;
            bit   act;
            lvl = (h % 2 == 0) ? !de : de;
            act = 1'b0;
            for (int k = 0; k < nfr; k++) begin
                int t;
                t = h0 + 2 * st[k] - ((fe != de) ? 1 : 0);
                if (pulse[k] && h >= t - 1 && h <= t + (r2 ? 2 : 0)) act = 1'b1;
            end
            for (int g = 0; g < 2; g++) begin
                if (g == 1 && both) begin
                    ext_clk[g] = 1'b0;
                    ext_fp[g]  = 1'b0;
                end else begin
                    ext_clk[g] = lvl;
                    ext_fp[g]  = act ^ inv;
                end
                if (h % 2 == 1) begin
                    int   qp;
                    logic db, sb;
                    logic [7:0] pd, ps;
                    qp = (h + 1 - h0) / 2;
                    db = 1'b0;
                    sb = 1'b0;
                    if (h + 1 >= h0) begin
                        for (int k = 0; k < nfr; k++) begin
                            if (qp >= st[k] && qp < st[k] + bits[k] * ppb) begin
                                int lp, lb;
                                lp = qp - st[k];
                                lb = lp / ppb;
                                pd = pat(g, k, lb / 8, 0);
                                ps = pat(g, k, lb / 8, 1);
                                db = pd[7 - lb % 8];
                                sb = ps[7 - lb % 8];
                                // R4: decoy value on the unselected half
                                if (r2 && ((lp % 2) != int'(hs))) begin
                                    db = ~db;
                                    sb = ~sb;
                                end
                            end
                        end
                    end
                    ext_dat[g] = db;
                    ext_sig[g] = sb;
                end
            end
            repeat (4) @(negedge clk);
        end
        repeat (10) @(negedge clk);

        for (int g = 0; g < 2; g++) begin
            int want;
            want = 0;
            if (slv[g]) for (int k = 0; k < nfr; k++) want += bits[k] / 8;
            chk(rx_cnt[g] == want, tag, $sformatf("link %0d byte count", g),
                longint'(rx_cnt[g]), longint'(want));
            chk(rs_cnt[g] == (slv[g] ? exp_rs : 0), "R9",
                $sformatf("link %0d resync count (%s)", g, tag),
                longint'(rs_cnt[g]), longint'(slv[g] ? exp_rs : 0));
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n      = 1'b0;
        share_clk  = 1'b0;
        link_slave = 2'b11;
        rate2x     = 2'b00;
        fp_edge    = 2'b00;
        dat_edge   = 2'b00;
        half_sel   = 2'b00;
        fp_type    = 4'b0;
        fp_inv     = 2'b00;
        ext_clk    = 2'b00;
        ext_fp     = 2'b00;
        ext_dat    = 2'b00;
        ext_sig    = 2'b00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk(byte_valid == 2'b00, "R1", "byte_valid after reset", longint'(byte_valid), 0);
        chk(resync == 2'b00, "R1", "resync after reset", longint'(resync), 0);
        chk(ts_num == '0 && frm_num == '0, "R1", "position after reset",
            longint'({ts_num, frm_num}), 0);

        // R2 / R3: single rate, all edge pairs
        run_case("R2", 0, 0, 0, 0, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        run_case("R3", 0, 0, 1, 0, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        run_case("R3", 0, 1, 0, 0, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        run_case("R3", 0, 1, 1, 0, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        // R4 / R5: double rate, both halves, all edge pairs
        run_case("R4", 1, 0, 0, 0, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        run_case("R4", 1, 1, 0, 1, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        run_case("R5", 1, 0, 1, 1, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        run_case("R5", 1, 1, 1, 0, 2'd0, 0, 0, 2'b11, 2, 0, 1);
        // R6: active-low pulse, CRC multiframe, free-running second frame
        run_case("R6", 0, 0, 0, 0, 2'd1, 1, 0, 2'b11, 2, 0, 0);
        // R7: signaling multiframe pulse early (frame reset + resync), spare code as basic
        run_case("R7", 0, 1, 0, 0, 2'd2, 0, 0, 2'b11, 2, 0, 1);
        run_case("R7", 0, 0, 0, 0, 2'd3, 0, 0, 2'b11, 2, 0, 1);
        // R9: pulse in the middle of a locked frame
        run_case("R9", 0, 0, 0, 0, 2'd0, 0, 0, 2'b11, 2, 80, 1);
        // R10: shared timing; link 2 own clock idle
        run_case("R10", 0, 0, 1, 0, 2'd0, 0, 1, 2'b11, 2, 0, 1);
        // R1 / R10: share requested but link 2 disabled
        run_case("R10", 0, 0, 0, 0, 2'd0, 0, 1, 2'b01, 1, 0, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule